// File: doc/BRIEF.md
# Flag-Setting Integer Execution Unit

This block is the arithmetic and logic execution unit of a small register machine. Each operation takes two unsigned operands of parameterised width and an operation code. It returns a result truncated to the operand width, a write-enable that says whether the result should be stored, an error strobe, and two flag bits: Z (zero/equal) and C (carry, meaning "no borrow"). Only some operations change the flags. Each operation code has its own rule for which flags it updates.

Most operations finish one cycle after they are accepted. Integer divide and greatest common divisor run iteratively. While they run the unit holds `busy_o` high and ignores new requests. A `done_o` pulse marks every completed operation. Divide uses a restoring shift-subtract loop that takes one cycle per quotient bit. GCD uses the binary (shift and subtract) method.

Top module: `flag_alu`

## Requirements
- R1: Operation codes on `op_i` are AND=0, OR=1, XOR=2, SRL=3, SLL=4, BTL=5, ADD=6, SUB=7, CMP=8, MUL=9, DIV=10, GCD=11. The codes AND, OR and XOR return the bitwise function of the two operands with `wr_o` high.
- R2: SRL and SLL shift `a_i` logically by `b_i` places. Any shift amount of W or more gives zero.
- R3: BTL returns one plus the index of the most significant set bit of `a_i`, and returns 0 when `a_i` is zero.
- R4: ADD, SUB and MUL results wrap modulo 2^W. No overflow indication exists.
- R5: SUB and CMP set Z when a_i equals b_i, otherwise they clear it. They set C when a_i >= b_i and clear it when a_i < b_i. CMP completes with `wr_o` low.
- R6: MUL sets Z when either operand is zero, otherwise it clears Z. MUL leaves C unchanged.
- R7: AND, OR, XOR, SRL, SLL, BTL, ADD, DIV and GCD leave both Z and C unchanged.
- R8: DIV returns the truncated integer quotient. When `b_i` is zero it instead completes one cycle after acceptance with `err_o` high and `wr_o` low.
- R9: GCD returns the greatest common divisor. The rules gcd(a,0)=a and gcd(0,b)=b apply, so gcd(0,0)=0.
- R10: A request is accepted when `start_i` is high and `busy_o` is low. Each accepted request yields exactly one `done_o` pulse, and `done_o` is never high while `busy_o` is high. Requests made while `busy_o` is high are ignored.
- R11: After reset, `done_o`, `busy_o`, `z_o` and `c_o` are all 0.
- R12: Codes 12 to 15 complete with `err_o` high and `wr_o` low, and both flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| busy_o | output | 1 | Iterative operation in progress |
| done_o | output | 1 | Completion pulse |
| wr_o | output | 1 | Result should be written, valid with done_o |
| err_o | output | 1 | Error, valid with done_o |
| res_o | output | W | Result |
| z_o | output | 1 | Z flag |
| c_o | output | 1 | C flag |

## Verification
Random operands are mixed with zero, one, all-ones, and small shift amounts that straddle the width. Equal operand pairs separate the Z rule from the C rule on SUB and CMP. A zero divisor separates the error path from a normal quotient. Zero and even GCD inputs exercise the common power-of-two factor and the early exit. A run of flag-setting operations followed by flag-neutral ones shows whether neutral codes disturb Z and C. A second request made during a divide shows whether busy requests are dropped.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
   typedef enum logic [3:0] {
      OP_AND = 4'd0,
      OP_OR  = 4'd1,
      OP_XOR = 4'd2,
      OP_SRL = 4'd3,
      OP_SLL = 4'd4,
      OP_BTL = 4'd5,
      OP_ADD = 4'd6,
      OP_SUB = 4'd7,
      OP_CMP = 4'd8,
      OP_MUL = 4'd9,
      OP_DIV = 4'd10,
      OP_GCD = 4'd11
   } alu_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DIV  = 2'd1,
      ST_GCD  = 2'd2
   } alu_st_e;
endpackage

// File: rtl/alu_single.sv
module alu_single import flag_alu_pkg::*; #(
   parameter int W = 16
) (
   input  logic [3:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] res_o
);
   localparam int SW = $clog2(W);
   localparam logic [W-1:0] WLIM = W'(W);

   logic         shift_ok;
   logic [W-1:0] bitlen;

   assign shift_ok = (b_i < WLIM);

   always_comb begin
      bitlen = '0;
      for (int i = 0; i < W; i++) begin
         if (a_i[i]) bitlen = W'(i + 1);
      end
   end

   always_comb begin
      case (op_i)
         OP_AND:  res_o = a_i & b_i;
         OP_OR:   res_o = a_i | b_i;
         OP_XOR:  res_o = a_i ^ b_i;
         OP_SRL:  res_o = shift_ok ? (a_i >> b_i[SW-1:0]) : '0;
         OP_SLL:  res_o = shift_ok ? (a_i << b_i[SW-1:0]) : '0;
         OP_BTL:  res_o = bitlen;
         OP_ADD:  res_o = a_i + b_i;
         OP_SUB:  res_o = a_i - b_i;
         OP_MUL:  res_o = a_i * b_i;
         default: res_o = '0;
      endcase
   end
endmodule

// File: rtl/alu_divider.sv
module alu_divider #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] dvd_i,
   input  logic [W-1:0] dvs_i,
   output logic         fin_o,
   output logic [W-1:0] quo_o
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  rem_q, dvs_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic [W:0]    trial, diff;
   logic          ge;

   assign trial = {rem_q, quo_o[W-1]};
   assign ge    = (trial >= {1'b0, dvs_q});
   assign diff  = trial - {1'b0, dvs_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         dvs_q <= '0;
         quo_o <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         fin_o <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         if (load_i) begin
            rem_q <= '0;
            dvs_q <= dvs_i;
            quo_o <= dvd_i;
            cnt_q <= CW'(W);
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= ge ? diff[W-1:0] : trial[W-1:0];
            quo_o <= {quo_o[W-2:0], ge};
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               run_q <= 1'b0;
               fin_o <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/alu_gcd.sv
module alu_gcd #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic         fin_o,
   output logic [W-1:0] g_o
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  x_q, y_q;
   logic [CW-1:0] k_q;
   logic          run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q   <= '0;
         y_q   <= '0;
         k_q   <= '0;
         run_q <= 1'b0;
         fin_o <= 1'b0;
         g_o   <= '0;
      end else begin
         fin_o <= 1'b0;
         if (load_i) begin
            x_q   <= x_i;
            y_q   <= y_i;
            k_q   <= '0;
            run_q <= 1'b1;
         end else if (run_q) begin
            if (x_q == '0 || y_q == '0) begin
               g_o   <= (x_q | y_q) << k_q;
               fin_o <= 1'b1;
               run_q <= 1'b0;
            end else if (!x_q[0] && !y_q[0]) begin
               x_q <= x_q >> 1;
               y_q <= y_q >> 1;
               k_q <= k_q + CW'(1);
            end else if (!x_q[0]) begin
               x_q <= x_q >> 1;
            end else if (!y_q[0]) begin
               y_q <= y_q >> 1;
            end else if (x_q >= y_q) begin
               x_q <= x_q - y_q;
            end else begin
               y_q <= y_q - x_q;
            end
         end
      end
   end
endmodule

// File: rtl/flag_alu.sv
module flag_alu import flag_alu_pkg::*; #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [3:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         busy_o,
   output logic         done_o,
   output logic         wr_o,
   output logic         err_o,
   output logic [W-1:0] res_o,
   output logic         z_o,
   output logic         c_o
);
   generate
      if (W < 2) begin : g_w_check
         $error("flag_alu: W must be at least 2");
      end
   endgenerate

   alu_st_e      st_q;
   logic         accept, div_load, gcd_load, div_fin, gcd_fin;
   logic [W-1:0] single_res, div_quo, gcd_val;

   assign busy_o   = (st_q != ST_IDLE);
   assign accept   = start_i && (st_q == ST_IDLE);
   assign div_load = accept && (op_i == OP_DIV) && (b_i != '0);
   assign gcd_load = accept && (op_i == OP_GCD);

   alu_single #(.W(W)) single_i (
      .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(single_res)
   );

   alu_divider #(.W(W)) div_i (
      .clk(clk), .rst_n(rst_n), .load_i(div_load),
      .dvd_i(a_i), .dvs_i(b_i), .fin_o(div_fin), .quo_o(div_quo)
   );

   alu_gcd #(.W(W)) gcd_i (
      .clk(clk), .rst_n(rst_n), .load_i(gcd_load),
      .x_i(a_i), .y_i(b_i), .fin_o(gcd_fin), .g_o(gcd_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         done_o <= 1'b0;
         wr_o   <= 1'b0;
         err_o  <= 1'b0;
         res_o  <= '0;
         z_o    <= 1'b0;
         c_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         wr_o   <= 1'b0;
         err_o  <= 1'b0;
         case (st_q)
            ST_IDLE: if (start_i) begin
               case (op_i)
                  OP_DIV: begin
                     if (b_i == '0) begin
                        done_o <= 1'b1;
                        err_o  <= 1'b1;
                     end else begin
                        st_q <= ST_DIV;
                     end
                  end
                  OP_GCD: st_q <= ST_GCD;
                  OP_CMP: begin
                     done_o <= 1'b1;
                     z_o    <= (a_i == b_i);
                     c_o    <= (a_i >= b_i);
                  end
                  OP_SUB: begin
                     done_o <= 1'b1;
                     wr_o   <= 1'b1;
                     res_o  <= single_res;
                     z_o    <= (a_i == b_i);
                     c_o    <= (a_i >= b_i);
                  end
                  OP_MUL: begin
                     done_o <= 1'b1;
                     wr_o   <= 1'b1;
                     res_o  <= single_res;
                     z_o    <= (a_i == '0) || (b_i == '0);
                  end
                  OP_AND, OP_OR, OP_XOR, OP_SRL, OP_SLL, OP_BTL, OP_ADD: begin
                     done_o <= 1'b1;
                     wr_o   <= 1'b1;
                     res_o  <= single_res;
                  end
                  default: begin
                     done_o <= 1'b1;
                     err_o  <= 1'b1;
                  end
               endcase
            end
            ST_DIV: if (div_fin) begin
               st_q   <= ST_IDLE;
               done_o <= 1'b1;
               wr_o   <= 1'b1;
               res_o  <= div_quo;
            end
            ST_GCD: if (gcd_fin) begin
               st_q   <= ST_IDLE;
               done_o <= 1'b1;
               wr_o   <= 1'b1;
               res_o  <= gcd_val;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk import flag_alu_pkg::*; #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic [3:0]   op_i,
   input logic [W-1:0] a_i,
   input logic [W-1:0] b_i,
   input logic         busy_o,
   input logic         done_o,
   input logic         wr_o,
   input logic         err_o,
   input logic         z_o,
   input logic         c_o
);
   logic [3:0] last_op;
   logic       taken;
   logic       flag_op;

   assign taken   = start_i && !busy_o;
   assign flag_op = (last_op == OP_SUB) || (last_op == OP_CMP) || (last_op == OP_MUL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_op <= 4'd0;
      else if (taken) last_op <= op_i;
   end

   assert_sub_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && (op_i == OP_SUB || op_i == OP_CMP)) |=>
      (z_o == ($past(a_i) == $past(b_i)) && c_o == ($past(a_i) >= $past(b_i))));

   assert_cmp_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && last_op == OP_CMP) |-> !wr_o);

   assert_mul_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && op_i == OP_MUL) |=>
      ($stable(c_o) && z_o == ($past(a_i) == '0 || $past(b_i) == '0)));

   assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && flag_op) |-> ($stable(z_o) && $stable(c_o)));

   assert_div_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && op_i == OP_DIV && b_i == '0) |=> (done_o && err_o && !wr_o));

   assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_err_nowrite_R12: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (done_o && !wr_o));
endmodule

bind flag_alu flag_alu_chk #(.W(W)) chk_i (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
   .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
   .wr_o(wr_o), .err_o(err_o), .z_o(z_o), .c_o(c_o)
);

// File: tb/flag_alu_tb_top.sv
`timescale 1ns/1ps
module flag_alu_tb_top;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [3:0]   op_i = 4'd0;
   logic [W-1:0] a_i = '0;
   logic [W-1:0] b_i = '0;
   logic         busy_o, done_o, wr_o, err_o, z_o, c_o;
   logic [W-1:0] res_o;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;
   logic z_m = 1'b0;
   logic c_m = 1'b0;

   always #2 clk = ~clk;

   flag_alu #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
      .wr_o(wr_o), .err_o(err_o), .res_o(res_o), .z_o(z_o), .c_o(c_o)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] ref_btl(input logic [W-1:0] a);
      logic [W-1:0] r = '0;
      for (int i = 0; i < W; i++) if (a[i]) r = W'(i + 1);
      return r;
   endfunction

   function automatic logic [W-1:0] ref_gcd(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] x = a, y = b, t;
      while (y != '0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd0, 4'd1, 4'd2: return "R1";
         4'd3, 4'd4:       return "R2";
         4'd5:             return "R3";
         4'd6:             return "R4";
         4'd7, 4'd8:       return "R5";
         4'd9:             return "R6";
         4'd10:            return "R8";
         4'd11:            return "R9";
         default:          return "R12";
      endcase
   endfunction

   task automatic run_op(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] er;
      logic ew, ee;
      int wait_cnt;
      string rq;
      ew = 1'b1; ee = 1'b0; er = '0;
      rq = req_of(op);
      case (op)
         4'd0: er = a & b;
         4'd1: er = a | b;
         4'd2: er = a ^ b;
         4'd3: er = (b >= W) ? '0 : a >> b;
         4'd4: er = (b >= W) ? '0 : a << b;
         4'd5: er = ref_btl(a);
         4'd6: er = a + b;
         4'd7: begin er = a - b; z_m = (a == b); c_m = (a >= b); end
         4'd8: begin ew = 1'b0; z_m = (a == b); c_m = (a >= b); end
         4'd9: begin er = a * b; z_m = (a == '0) || (b == '0); end
         4'd10: if (b == '0) begin ew = 1'b0; ee = 1'b1; end else er = a / b;
         4'd11: er = ref_gcd(a, b);
         default: begin ew = 1'b0; ee = 1'b1; end
      endcase
      @(negedge clk);
      start_i = 1'b1; op_i = op; a_i = a; b_i = b;
      @(negedge clk);
      start_i = 1'b0;
      wait_cnt = 0;
      while (!done_o && wait_cnt < 500) begin
         @(negedge clk);
         wait_cnt++;
      end
      chk(done_o, {rq, " done"}, done_o, 1);
      if (op == 4'd10 && b == '0) chk(wait_cnt == 0, "R8 latency", wait_cnt, 0);
      chk(wr_o == ew, {rq, " wr"}, wr_o, ew);
      chk(err_o == ee, {rq, " err"}, err_o, ee);
      if (ew) chk(res_o == er, {rq, " result"}, res_o, er);
      chk(z_o == z_m, {rq, " R7 z flag"}, z_o, z_m);
      chk(c_o == c_m, {rq, " R7 c flag"}, c_o, c_m);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(!done_o && !busy_o, "R11 done/busy", {done_o, busy_o}, 0);
      chk(!z_o && !c_o, "R11 flags", {z_o, c_o}, 0);

      // directed corners
      run_op(4'd0, 16'hF0F0, 16'hFF00);
      run_op(4'd1, 16'h0F0F, 16'h1100);
      run_op(4'd2, 16'hAAAA, 16'hFFFF);
      run_op(4'd3, 16'h8000, 16'd15);
      run_op(4'd3, 16'hFFFF, 16'd16);
      run_op(4'd4, 16'h0001, 16'd15);
      run_op(4'd4, 16'hFFFF, 16'd200);
      run_op(4'd5, 16'h0000, 16'd0);
      run_op(4'd5, 16'h8000, 16'd0);
      run_op(4'd5, 16'h0001, 16'd0);
      run_op(4'd6, 16'hFFFF, 16'd2);
      run_op(4'd7, 16'd5, 16'd5);
      run_op(4'd7, 16'd3, 16'd9);
      run_op(4'd8, 16'd9, 16'd3);
      run_op(4'd8, 16'd4, 16'd4);
      run_op(4'd9, 16'd0, 16'd77);
      run_op(4'd9, 16'h0100, 16'h0100);
      run_op(4'd6, 16'd1, 16'd1);
      run_op(4'd10, 16'd1000, 16'd7);
      run_op(4'd10, 16'd55, 16'd0);
      run_op(4'd10, 16'hFFFF, 16'd1);
      run_op(4'd11, 16'd48, 16'd180);
      run_op(4'd11, 16'd37, 16'd0);
      run_op(4'd11, 16'd0, 16'd0);
      run_op(4'd11, 16'h8000, 16'h4000);
      run_op(4'd13, 16'd1, 16'd2);

      // R10: request during divide is dropped
      begin
         int dones = 0;
         @(negedge clk);
         start_i = 1'b1; op_i = 4'd10; a_i = 16'd1000; b_i = 16'd7;
         @(negedge clk);
         op_i = 4'd6; a_i = 16'd1; b_i = 16'd1;
         chk(busy_o, "R10 busy after divide accept", busy_o, 1);
         repeat (3) @(negedge clk);
         start_i = 1'b0;
         for (int i = 0; i < 100 && !done_o; i++) @(negedge clk);
         chk(done_o && res_o == 16'd142, "R10 divide result kept", res_o, 142);
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (done_o) dones++;
         end
         chk(dones == 0, "R10 extra done pulses", dones, 0);
      end

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [3:0] op;
         logic [W-1:0] a, b;
         op = 4'($urandom_range(0, 15));
         a = W'($urandom);
         b = W'($urandom);
         case ($urandom_range(0, 5))
            0: a = '0;
            1: b = '0;
            2: b = W'($urandom_range(0, 20));
            3: b = a;
            default: ;
         endcase
         run_op(op, a, b);
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule